// File: doc/BRIEF.md
# Port-Addressed Framed FIFO Bus Bridge

This block sits between a host and an eight-port network controller. Each port has two queues. One queue holds received words that the host reads. The other holds words the host writes for transmission. Every queue entry is a 64-bit data word with three kinds of sideband: a byte-lane valid mask, a first-word-of-frame marker and a last-word-of-frame marker. The sideband travels with the word through the queue.

The host reaches all sixteen queues over one synchronous bus, which it clocks itself. On each clock edge where both active-low strobes (select and transfer) are low, the 3-bit port number picks a port and the direction bit picks a queue. One word then moves. A read takes the oldest word of that port's receive queue. A write appends a word to that port's transmit queue.

On the network side, each receive queue is filled through its own push strobe and flags when it is full. Each transmit queue shows its oldest word at all times, can be drained through its own pop strobe, and flags when it is empty. Every queue counts the bytes it holds, using the lane-valid mask of each word. Two 8-bit ready vectors tell the host which ports are worth serving.

Top module: `framed_fifo_hub`

## Requirements
- R1: While reset (active high) is asserted at a clock edge, all queues become empty, both ready vectors are 0 and the error vector is 0. At the first edge after reset is released, every transmit-ready bit rises (the queues are empty) and every receive-ready bit stays 0.
- R2: A word moves only at an edge where `bus_cs_n` and `bus_xfer_n` are both 0. If either one is 1, no queue changes, the read outputs hold their values, and the error vector is 0.
- R3: A read (`bus_dir`=1) of a non-empty receive queue removes its oldest word. The word's data, lane mask and both frame markers appear on the read outputs one edge later and hold until the next bus read.
- R4: A write (`bus_dir`=0) to a non-full transmit queue appends the bus word and its sideband. The words then show up in order, oldest first, on that port's transmit output lanes (`tx_out_*`, port p at data bits p*64 upward).
- R5: `rx_ready[p]` is 1 exactly when receive queue p holds at least RX_THR_BYTES bytes. The byte count is the sum of the set lane-valid bits over the words held. The flag is updated at the same edge as the queue.
- R6: `tx_ready[p]` is 1 exactly when (DEPTH − words held) × 8 in transmit queue p is at least TX_THR_BYTES. The flag is updated at the same edge as the queue.
- R7: A read of an empty receive queue changes nothing. One edge later, the read outputs show zero data, zero lane mask and cleared markers, and `err_pulse` has only bit p set, for one cycle.
- R8: A write to a full transmit queue changes nothing, and one edge later `err_pulse` has only bit p set, for one cycle.
- R9: Only the queue picked by `bus_port` (binary port number) and `bus_dir` is affected by a bus transfer. All other ports' queues and flags are unaffected.
- R10: A local push into a full receive queue, or a local pop of an empty transmit queue, is ignored. `rx_full[p]` is 1 when DEPTH words are held, and `tx_empty[p]` is 1 when none are.
- R11: A bus access and a local access to the same queue at the same edge both take effect. Whether the queue is empty or full is judged on its state before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock from the host |
| rst | input | 1 | Synchronous reset, active high |
| bus_cs_n | input | 1 | Select strobe, active low |
| bus_xfer_n | input | 1 | Transfer strobe, active low |
| bus_dir | input | 1 | 1 = read receive queue, 0 = write transmit queue |
| bus_port | input | 3 | Binary port number |
| bus_wdata | input | 64 | Write data word |
| bus_wbval | input | 8 | Write lane-valid mask, bit i covers data bits 8i+7..8i |
| bus_wsof | input | 1 | Write word starts a frame |
| bus_weof | input | 1 | Write word ends a frame |
| bus_rdata | output | 64 | Read data word |
| bus_rbval | output | 8 | Read lane-valid mask |
| bus_rsof | output | 1 | Read word starts a frame |
| bus_reof | output | 1 | Read word ends a frame |
| err_pulse | output | 8 | One-cycle per-port error for a refused transfer |
| rx_ready | output | 8 | Receive threshold reached, per port |
| tx_ready | output | 8 | Transmit free space threshold reached, per port |
| rx_push | input | 8 | Local push strobe per receive queue |
| rx_in_data | input | 512 | Local push data, 64 bits per port |
| rx_in_bval | input | 64 | Local push lane masks, 8 bits per port |
| rx_in_sof | input | 8 | Local push frame-start markers |
| rx_in_eof | input | 8 | Local push frame-end markers |
| rx_full | output | 8 | Receive queue full, per port |
| tx_pop | input | 8 | Local pop strobe per transmit queue |
| tx_out_data | output | 512 | Oldest transmit word per port |
| tx_out_bval | output | 64 | Oldest transmit lane mask per port |
| tx_out_sof | output | 8 | Oldest transmit frame-start marker |
| tx_out_eof | output | 8 | Oldest transmit frame-end marker |
| tx_empty | output | 8 | Transmit queue empty, per port |

## Verification
The read outputs and the error vector come from one register stage, so they are due at the edge after the edge that accepts the transfer. The ready vectors, full and empty flags and transmit head words change at that same accepting edge. The bench drives all inputs 2 ns after a rising edge. It predicts the effect of the next edge from its own model state before that edge, and compares every output 2 ns after the edge. This means each result is checked exactly one register stage after its cause and never while the edge is settling.

// File: rtl/ffh_pkg.sv
package ffh_pkg;

    localparam int LANES  = 8;
    localparam int WORD_W = LANES * 8;
    localparam int LCNT_W = $clog2(LANES + 1);

    // Queue entry; bit order {sof, eof, bval, data} is the packing used on the local lanes too.
    typedef struct packed {
        logic               sof;
        logic               eof;
        logic [LANES-1:0]   bval;
        logic [WORD_W-1:0]  data;
    } ffh_word_t;

    typedef enum logic {
        DIR_WRITE = 1'b0,
        DIR_READ  = 1'b1
    } ffh_dir_e;

    // Number of valid byte lanes in one word.
    function automatic logic [LCNT_W-1:0] lane_count(input logic [LANES-1:0] mask);
        logic [LCNT_W-1:0] n;
        n = '0;
        for (int i = 0; i < LANES; i++) begin
            n = n + LCNT_W'(mask[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/ffh_fifo.sv
module ffh_fifo
    import ffh_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int THR_BYTES = 32,
    parameter bit FREE_MODE = 1'b0,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int BW = $clog2(DEPTH * LANES + 1)
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  ffh_word_t push_word,
    input  logic      pop,
    output ffh_word_t head_word,
    output logic      empty,
    output logic      full,
    output logic      ready
);

    ffh_word_t         mem [DEPTH];
    logic [AW-1:0]     wptr, rptr;
    logic [CW-1:0]     words, words_nx;
    logic [BW-1:0]     bytes, bytes_nx, add_b, sub_b;
    logic              push_ok, pop_ok, ready_nx;

    assign empty     = (words == '0);
    assign full      = (words == CW'(DEPTH));
    assign push_ok   = push && !full;
    assign pop_ok    = pop && !empty;
    assign head_word = mem[rptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        add_b    = push_ok ? BW'(lane_count(push_word.bval)) : '0;
        sub_b    = pop_ok  ? BW'(lane_count(head_word.bval)) : '0;
        words_nx = words + CW'(push_ok) - CW'(pop_ok);
        bytes_nx = bytes + add_b - sub_b;
    end

    generate
        if (FREE_MODE) begin : g_free
            always_comb ready_nx = ((DEPTH - int'(words_nx)) * LANES) >= THR_BYTES;
        end else begin : g_held
            always_comb ready_nx = int'(bytes_nx) >= THR_BYTES;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= push_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            words <= '0;
            bytes <= '0;
            ready <= 1'b0;
        end else begin
            if (push_ok) wptr <= bump(wptr);
            if (pop_ok)  rptr <= bump(rptr);
            words <= words_nx;
            bytes <= bytes_nx;
            ready <= ready_nx;
        end
    end

    assert_word_bound_R10: assert property (@(posedge clk) disable iff (rst)
        words <= CW'(DEPTH));

    assert_byte_bound_R5: assert property (@(posedge clk) disable iff (rst)
        int'(bytes) <= int'(words) * LANES);

    assert_full_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (words == $past(words)));

    assert_empty_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> empty);

endmodule

// File: rtl/ffh_bus_decode.sv
module ffh_bus_decode
    import ffh_pkg::*;
#(
    parameter int NPORT = 8,
    localparam int PW = $clog2(NPORT)
) (
    input  logic             cs_n,
    input  logic             xfer_n,
    input  logic             dir,
    input  logic [PW-1:0]    port,
    output logic [NPORT-1:0] rd_sel,
    output logic [NPORT-1:0] wr_sel
);

    logic go;
    assign go = !cs_n && !xfer_n;

    generate
        for (genvar g = 0; g < NPORT; g++) begin : g_sel
            assign rd_sel[g] = go && (dir == DIR_READ)  && (port == PW'(g));
            assign wr_sel[g] = go && (dir == DIR_WRITE) && (port == PW'(g));
        end
    endgenerate

endmodule

// File: rtl/ffh_resp.sv
module ffh_resp
    import ffh_pkg::*;
#(
    parameter int NPORT = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPORT-1:0] rd_sel,
    input  logic [NPORT-1:0] wr_sel,
    input  logic [NPORT-1:0] rx_empty,
    input  logic [NPORT-1:0] tx_full,
    input  ffh_word_t        rx_head [NPORT],
    output ffh_word_t        rd_word,
    output logic [NPORT-1:0] err
);

    ffh_word_t        sel_word;
    logic             rd_hit;
    logic [NPORT-1:0] err_nx;

    always_comb begin
        sel_word = '0;
        for (int i = 0; i < NPORT; i++) begin
            if (rd_sel[i]) sel_word = rx_head[i];
        end
        rd_hit = |(rd_sel & ~rx_empty);
        err_nx = (rd_sel & rx_empty) | (wr_sel & tx_full);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_word <= '0;
            err     <= '0;
        end else begin
            err <= err_nx;
            if (|rd_sel) rd_word <= rd_hit ? sel_word : '0;
        end
    end

endmodule

// File: rtl/framed_fifo_hub.sv
module framed_fifo_hub
    import ffh_pkg::*;
#(
    parameter int NPORT        = 8,
    parameter int DEPTH        = 8,
    parameter int RX_THR_BYTES = 32,
    parameter int TX_THR_BYTES = 32,
    localparam int PW = $clog2(NPORT)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_cs_n,
    input  logic                     bus_xfer_n,
    input  logic                     bus_dir,
    input  logic [PW-1:0]            bus_port,
    input  logic [WORD_W-1:0]        bus_wdata,
    input  logic [LANES-1:0]         bus_wbval,
    input  logic                     bus_wsof,
    input  logic                     bus_weof,
    output logic [WORD_W-1:0]        bus_rdata,
    output logic [LANES-1:0]         bus_rbval,
    output logic                     bus_rsof,
    output logic                     bus_reof,
    output logic [NPORT-1:0]         err_pulse,
    output logic [NPORT-1:0]         rx_ready,
    output logic [NPORT-1:0]         tx_ready,
    input  logic [NPORT-1:0]         rx_push,
    input  logic [NPORT*WORD_W-1:0]  rx_in_data,
    input  logic [NPORT*LANES-1:0]   rx_in_bval,
    input  logic [NPORT-1:0]         rx_in_sof,
    input  logic [NPORT-1:0]         rx_in_eof,
    output logic [NPORT-1:0]         rx_full,
    input  logic [NPORT-1:0]         tx_pop,
    output logic [NPORT*WORD_W-1:0]  tx_out_data,
    output logic [NPORT*LANES-1:0]   tx_out_bval,
    output logic [NPORT-1:0]         tx_out_sof,
    output logic [NPORT-1:0]         tx_out_eof,
    output logic [NPORT-1:0]         tx_empty
);

    logic [NPORT-1:0] rd_sel, wr_sel, rx_empty, tx_full;
    ffh_word_t        rx_head [NPORT];
    ffh_word_t        tx_head [NPORT];
    ffh_word_t        bus_word, rd_word;

    assign bus_word = '{sof: bus_wsof, eof: bus_weof, bval: bus_wbval, data: bus_wdata};

    ffh_bus_decode #(.NPORT(NPORT)) u_decode (
        .cs_n   (bus_cs_n),
        .xfer_n (bus_xfer_n),
        .dir    (bus_dir),
        .port   (bus_port),
        .rd_sel (rd_sel),
        .wr_sel (wr_sel)
    );

    generate
        for (genvar g = 0; g < NPORT; g++) begin : g_port
            ffh_word_t rx_in_word;
            assign rx_in_word = '{sof:  rx_in_sof[g],
                                  eof:  rx_in_eof[g],
                                  bval: rx_in_bval[g*LANES +: LANES],
                                  data: rx_in_data[g*WORD_W +: WORD_W]};

            ffh_fifo #(.DEPTH(DEPTH), .THR_BYTES(RX_THR_BYTES), .FREE_MODE(1'b0)) u_rxq (
                .clk       (clk),
                .rst       (rst),
                .push      (rx_push[g]),
                .push_word (rx_in_word),
                .pop       (rd_sel[g]),
                .head_word (rx_head[g]),
                .empty     (rx_empty[g]),
                .full      (rx_full[g]),
                .ready     (rx_ready[g])
            );

            ffh_fifo #(.DEPTH(DEPTH), .THR_BYTES(TX_THR_BYTES), .FREE_MODE(1'b1)) u_txq (
                .clk       (clk),
                .rst       (rst),
                .push      (wr_sel[g]),
                .push_word (bus_word),
                .pop       (tx_pop[g]),
                .head_word (tx_head[g]),
                .empty     (tx_empty[g]),
                .full      (tx_full[g]),
                .ready     (tx_ready[g])
            );

            assign tx_out_data[g*WORD_W +: WORD_W] = tx_head[g].data;
            assign tx_out_bval[g*LANES +: LANES]   = tx_head[g].bval;
            assign tx_out_sof[g]                   = tx_head[g].sof;
            assign tx_out_eof[g]                   = tx_head[g].eof;
        end
    endgenerate

    ffh_resp #(.NPORT(NPORT)) u_resp (
        .clk      (clk),
        .rst      (rst),
        .rd_sel   (rd_sel),
        .wr_sel   (wr_sel),
        .rx_empty (rx_empty),
        .tx_full  (tx_full),
        .rx_head  (rx_head),
        .rd_word  (rd_word),
        .err      (err_pulse)
    );

    assign bus_rdata = rd_word.data;
    assign bus_rbval = rd_word.bval;
    assign bus_rsof  = rd_word.sof;
    assign bus_reof  = rd_word.eof;

    logic bus_go;
    assign bus_go = !bus_cs_n && !bus_xfer_n;

    assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !bus_go |=> ($stable(bus_rdata) && $stable(bus_rbval) && (err_pulse == '0)));

    assert_empty_read_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_go && bus_dir && rx_empty[bus_port]) |=>
            ((bus_rbval == '0) && (bus_rdata == '0) && !bus_rsof && !bus_reof &&
             (err_pulse == (NPORT'(1) << $past(bus_port)))));

    assert_full_write_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_go && !bus_dir && tx_full[bus_port]) |=>
            (err_pulse == (NPORT'(1) << $past(bus_port))));

    assert_err_single_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(err_pulse));

endmodule

// File: tb/tb_framed_fifo_hub.sv
module tb_framed_fifo_hub;

    localparam int NP  = 8;
    localparam int DP  = 8;
    localparam int RXT = 32;
    localparam int TXT = 32;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic           rst;
    logic           bus_cs_n, bus_xfer_n, bus_dir;
    logic [2:0]     bus_port;
    logic [63:0]    bus_wdata;
    logic [7:0]     bus_wbval;
    logic           bus_wsof, bus_weof;
    logic [63:0]    bus_rdata;
    logic [7:0]     bus_rbval;
    logic           bus_rsof, bus_reof;
    logic [NP-1:0]  err_pulse, rx_ready, tx_ready;
    logic [NP-1:0]  rx_push, rx_in_sof, rx_in_eof, rx_full;
    logic [NP*64-1:0] rx_in_data, tx_out_data;
    logic [NP*8-1:0]  rx_in_bval, tx_out_bval;
    logic [NP-1:0]  tx_pop, tx_out_sof, tx_out_eof, tx_empty;

    framed_fifo_hub #(.NPORT(NP), .DEPTH(DP), .RX_THR_BYTES(RXT), .TX_THR_BYTES(TXT)) dut (
        .clk(clk), .rst(rst),
        .bus_cs_n(bus_cs_n), .bus_xfer_n(bus_xfer_n), .bus_dir(bus_dir), .bus_port(bus_port),
        .bus_wdata(bus_wdata), .bus_wbval(bus_wbval), .bus_wsof(bus_wsof), .bus_weof(bus_weof),
        .bus_rdata(bus_rdata), .bus_rbval(bus_rbval), .bus_rsof(bus_rsof), .bus_reof(bus_reof),
        .err_pulse(err_pulse), .rx_ready(rx_ready), .tx_ready(tx_ready),
        .rx_push(rx_push), .rx_in_data(rx_in_data), .rx_in_bval(rx_in_bval),
        .rx_in_sof(rx_in_sof), .rx_in_eof(rx_in_eof), .rx_full(rx_full),
        .tx_pop(tx_pop), .tx_out_data(tx_out_data), .tx_out_bval(tx_out_bval),
        .tx_out_sof(tx_out_sof), .tx_out_eof(tx_out_eof), .tx_empty(tx_empty)
    );

    int checks = 0;
    int fails  = 0;

    logic [73:0]   rxm [NP][DP];
    logic [73:0]   txm [NP][DP];
    int            rxn [NP];
    int            txn [NP];
    logic [73:0]   e_rword;
    logic [NP-1:0] e_err;

    task automatic check_eq(input string req, input string what,
                            input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int pc(input logic [7:0] v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += int'(v[i]);
        return n;
    endfunction

    function automatic int rx_bytes(input int p);
        int s = 0;
        for (int k = 0; k < rxn[p]; k++) s += pc(rxm[p][k][71:64]);
        return s;
    endfunction

    task automatic idle_inputs();
        bus_cs_n = 1'b1; bus_xfer_n = 1'b1; bus_dir = 1'b0; bus_port = '0;
        bus_wdata = '0; bus_wbval = '0; bus_wsof = 1'b0; bus_weof = 1'b0;
        rx_push = '0; tx_pop = '0;
    endtask

    task automatic bus_set(input logic dir, input int p, input logic [63:0] d,
                           input logic [7:0] bv, input logic s, input logic e);
        bus_cs_n = 1'b0; bus_xfer_n = 1'b0; bus_dir = dir; bus_port = 3'(p);
        bus_wdata = d; bus_wbval = bv; bus_wsof = s; bus_weof = e;
    endtask

    task automatic compare();
        check_eq("R3", "read word", {6'b0, bus_rsof, bus_reof, bus_rbval, bus_rdata}, {6'b0, e_rword});
        check_eq("R7_R8", "err_pulse", {72'b0, err_pulse}, {72'b0, e_err});
        for (int i = 0; i < NP; i++) begin
            check_eq("R5", $sformatf("rx_ready[%0d]", i), {79'b0, rx_ready[i]}, {79'b0, rx_bytes(i) >= RXT});
            check_eq("R6", $sformatf("tx_ready[%0d]", i), {79'b0, tx_ready[i]}, {79'b0, ((DP - txn[i]) * 8) >= TXT});
            check_eq("R10", $sformatf("rx_full[%0d]", i), {79'b0, rx_full[i]}, {79'b0, rxn[i] == DP});
            check_eq("R10", $sformatf("tx_empty[%0d]", i), {79'b0, tx_empty[i]}, {79'b0, txn[i] == 0});
            if (txn[i] > 0)
                check_eq("R4", $sformatf("tx head[%0d]", i),
                         {6'b0, tx_out_sof[i], tx_out_eof[i], tx_out_bval[i*8 +: 8], tx_out_data[i*64 +: 64]},
                         {6'b0, txm[i][0]});
        end
    endtask

    // One clock edge: predict from the model's pre-edge state, then compare 2 ns after the edge.
    task automatic step();
        logic          go, do_rd, do_wr;
        int            p;
        logic [NP-1:0] rxgo, txgo;
        logic [73:0]   rxw [NP];
        logic [73:0]   bw;
        go = !bus_cs_n && !bus_xfer_n;
        p  = int'(bus_port);
        do_rd = 1'b0; do_wr = 1'b0;
        e_err = '0;
        bw = {bus_wsof, bus_weof, bus_wbval, bus_wdata};
        if (go && bus_dir) begin
            if (rxn[p] == 0) begin e_err[p] = 1'b1; e_rword = '0; end
            else begin e_rword = rxm[p][0]; do_rd = 1'b1; end
        end
        if (go && !bus_dir) begin
            if (txn[p] == DP) e_err[p] = 1'b1;
            else do_wr = 1'b1;
        end
        for (int i = 0; i < NP; i++) begin
            rxgo[i] = rx_push[i] && (rxn[i] < DP);
            txgo[i] = tx_pop[i] && (txn[i] > 0);
            rxw[i]  = {rx_in_sof[i], rx_in_eof[i], rx_in_bval[i*8 +: 8], rx_in_data[i*64 +: 64]};
        end
        @(posedge clk);
        #2;
        if (do_rd) begin
            for (int k = 0; k < DP - 1; k++) rxm[p][k] = rxm[p][k+1];
            rxn[p]--;
        end
        for (int i = 0; i < NP; i++) begin
            if (rxgo[i]) begin rxm[i][rxn[i]] = rxw[i]; rxn[i]++; end
            if (txgo[i]) begin
                for (int k = 0; k < DP - 1; k++) txm[i][k] = txm[i][k+1];
                txn[i]--;
            end
        end
        if (do_wr) begin txm[p][txn[p]] = bw; txn[p]++; end
        compare();
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1;
        idle_inputs();
        rx_in_data = '0; rx_in_bval = '0; rx_in_sof = '0; rx_in_eof = '0;
        for (int i = 0; i < NP; i++) begin rxn[i] = 0; txn[i] = 0; end
        e_rword = '0; e_err = '0;
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        check_eq("R1", "rx_ready in reset", {72'b0, rx_ready}, 80'h0);
        check_eq("R1", "tx_ready in reset", {72'b0, tx_ready}, 80'h0);
        check_eq("R1", "err in reset", {72'b0, err_pulse}, 80'h0);
        check_eq("R1", "tx_empty in reset", {72'b0, tx_empty}, 80'hff);
        rst = 1'b0;
        step();
        check_eq("R1", "tx_ready after reset", {72'b0, tx_ready}, 80'hff);

        // R7: read of an empty receive queue
        bus_set(1'b1, 3, 64'h1234, 8'hff, 1'b1, 1'b1);
        step();
        check_eq("R7", "empty read err", {72'b0, err_pulse}, 80'h08);
        check_eq("R7", "empty read mask", {72'b0, bus_rbval}, 80'h0);

        // R2: one strobe high blocks the transfer
        bus_set(1'b0, 5, 64'hdead, 8'hff, 1'b0, 1'b0); bus_cs_n = 1'b1;
        step();
        check_eq("R2", "cs high write", {79'b0, tx_empty[5]}, 80'h1);
        bus_set(1'b0, 5, 64'hdead, 8'hff, 1'b0, 1'b0); bus_xfer_n = 1'b1;
        step();
        check_eq("R2", "xfer high write", {79'b0, tx_empty[5]}, 80'h1);
        check_eq("R2", "no err when idle", {72'b0, err_pulse}, 80'h0);

        // R9, R4: write to port 5 only
        bus_set(1'b0, 5, 64'hA5A5_0001, 8'h0f, 1'b1, 1'b0);
        step();
        check_eq("R9", "only port 5 filled", {72'b0, tx_empty}, 80'hdf);
        check_eq("R4", "port 5 head", {72'b0, tx_out_bval[40 +: 8]}, 80'h0f);

        // R8, R6: fill port 5 and overflow it
        for (int k = 1; k < DP; k++) begin
            bus_set(1'b0, 5, 64'hA5A5_0000 + 64'(k), 8'hff, 1'b0, k == DP - 1);
            step();
        end
        check_eq("R6", "tx_ready[5] low when full", {79'b0, tx_ready[5]}, 80'h0);
        bus_set(1'b0, 5, 64'hBAD, 8'hff, 1'b0, 1'b0);
        step();
        check_eq("R8", "full write err", {72'b0, err_pulse}, 80'h20);
        idle_inputs();
        tx_pop[5] = 1'b1;
        repeat (3) step();
        idle_inputs();

        // R11: local push and bus read of the same queue together
        rx_push[2] = 1'b1; rx_in_data[128 +: 64] = 64'h77; rx_in_bval[16 +: 8] = 8'h03;
        bus_set(1'b1, 2, '0, '0, 1'b0, 1'b0);
        step();
        check_eq("R11", "read empty while pushing", {72'b0, err_pulse}, 80'h04);
        rx_in_data[128 +: 64] = 64'h88; rx_in_bval[16 +: 8] = 8'hff; rx_in_sof[2] = 1'b1;
        step();
        check_eq("R11", "read plus push data", {16'b0, bus_rdata}, 80'h77);
        check_eq("R11", "read plus push no err", {72'b0, err_pulse}, 80'h0);
        idle_inputs(); rx_in_sof = '0;

        // R10: overfill receive queue 6 locally
        rx_push[6] = 1'b1; rx_in_bval[48 +: 8] = 8'hff;
        for (int k = 0; k < DP + 1; k++) begin
            rx_in_data[384 +: 64] = 64'(k + 100);
            step();
        end
        check_eq("R10", "rx_full[6]", {79'b0, rx_full[6]}, 80'h1);
        check_eq("R5", "rx_ready[6]", {79'b0, rx_ready[6]}, 80'h1);
        idle_inputs();
        tx_pop[0] = 1'b1;
        step();
        check_eq("R10", "pop empty tx ignored", {79'b0, tx_empty[0]}, 80'h1);
        idle_inputs();
        for (int k = 0; k < DP; k++) begin
            bus_set(1'b1, 6, '0, '0, 1'b0, 1'b0);
            step();
        end
        check_eq("R3", "last word of port 6", {16'b0, bus_rdata}, 80'd107);

        // Random traffic in alternating fill and drain phases
        for (int c = 0; c < 4000; c++) begin
            bit fill;
            fill = ((c / 400) % 2) == 0;
            idle_inputs();
            bus_cs_n   = ($urandom % 6) == 0;
            bus_xfer_n = ($urandom % 6) == 0;
            bus_port   = 3'($urandom);
            bus_dir    = fill ? (($urandom % 4) == 0) : (($urandom % 4) != 0);
            bus_wdata  = {$urandom, $urandom};
            bus_wbval  = 8'($urandom);
            bus_wsof   = 1'($urandom);
            bus_weof   = 1'($urandom);
            for (int i = 0; i < NP; i++) begin
                rx_push[i] = fill ? (($urandom % 3) == 0) : (($urandom % 8) == 0);
                tx_pop[i]  = fill ? (($urandom % 8) == 0) : (($urandom % 3) == 0);
                rx_in_data[i*64 +: 64] = {$urandom, $urandom};
                rx_in_bval[i*8 +: 8]   = 8'($urandom);
                rx_in_sof[i] = 1'($urandom);
                rx_in_eof[i] = 1'($urandom);
            end
            step();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule